// File: doc/BRIEF.md
# Fuse program and read access controller

This block controls a one-time-programmable bit array, modelled as registers and organised as pages of rows of 32-bit words. A bit can only change from 0 to 1. Software reaches the block through two request strobes that share one packed address. A program request names a single bit. The block checks it against a layered set of protections and then either sets the bit or reports an error. A read request names a row and returns that 32-bit word, unless the row holds key material and is read-protected.

The protections are layered as follows:
- A global program-enable level.
- A sticky software lock that guards a range of rows.
- A per-row table that names a lock fuse stored inside the array itself.
- A protected range on page 2, guarded by a fuse on page 0.

Every request finishes with a one-cycle done pulse, plus an error pulse when the request fails. These pulses feed an interrupt block. The block also keeps a per-page test-bit status and a cache-done flag. At reset it forces the anchor fuses of every page.

Top module: `fuse_access_ctrl`

## Requirements
- R1: The address packs the column in bits [4:0], the row in bits [12:5] and the page in bits [16:13]. A read uses the page and row and ignores the column.
- R2: While `pgm_en` is 0, every program request is refused with `pgm_err`, and the array is left unchanged.
- R3: A `lock_wr` cycle with `lock_wdata` = 1 sets `lock_q`, and only reset clears it. Writing 0 has no effect. While `lock_q` is 1, programming any bit of page 0 rows 44 to 51 is refused.
- R4: On page 0, a programmed lock fuse refuses the whole row it guards. Row 4 is guarded by its own column 31. Every other guarded row is guarded by a column of row 43:
  - rows 64–71 by column 6
  - rows 72–79 by column 7
  - rows 80–87 by column 8
  - rows 12–19 by column 11
  - rows 20–27 by column 13
  - rows 28–35 by column 15
  - rows 8–11 by column 27
  - row 37 by column 28

  Rows not listed are never refused by this table.
- R5: On page 2, positions from row 129 column 0 up to row 255 column 27 are refused once page 0 row 43 column 16 is 1. The rest of page 2, and pages 1 and above other than 2, are never locked.
- R6: Every accepted program request pulses `pgm_done` for one cycle. `pgm_err` pulses in the same cycle when the request is refused or the page is not below PAGES. Setting a bit that is already 1 is not an error, and the bit stays 1.
- R7: A read of page 0 rows 12 to 35 returns 0 and pulses `rd_err`. Every accepted read pulses `rd_done`. `rd_data` changes only with `rd_done`.
- R8: After reset, row 0 of every page holds 1 in columns 1 and 27 (0x0800_0002) and every other bit is 0. `tbit_status`, `cache_done`, `lock_q` and the pulse outputs are 0.
- R9: `tbit_status[p]` is 1 when columns 28–31 of row 0 on page p are all 1. It is refreshed in the commit cycle of a successful program of row 0 column 28 or higher, and on `cache_load`.
- R10: A `cache_load` cycle sets `cache_done`, which stays set until reset.
- R11: A request is accepted at a clock edge where `busy` is 0. `busy` is then 1 for one cycle, and the done pulse appears after the next edge. Requests are ignored while `busy` is 1. If both strobes are high, the program request wins and the read is dropped.
- R12: A read of a page not below PAGES returns 0 and pulses `rd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_en | input | 1 | Global program enable |
| lock_wr | input | 1 | Strobe to write the sticky row-range lock |
| lock_wdata | input | 1 | Value written with `lock_wr`; only 1 has effect |
| pgm_req | input | 1 | Program request strobe |
| rd_req | input | 1 | Read request strobe |
| addr | input | 17 | Packed page/row/column address |
| cache_load | input | 1 | Refresh test-bit status and set cache-done |
| busy | output | 1 | A request is in its commit cycle |
| rd_data | output | 32 | Word returned by the last read |
| pgm_done | output | 1 | Program completion pulse |
| pgm_err | output | 1 | Program refused pulse |
| rd_done | output | 1 | Read completion pulse |
| rd_err | output | 1 | Read refused pulse |
| tbit_status | output | 3 | Per-page test-bit flags |
| cache_done | output | 1 | Sticky cache-load completion |
| lock_q | output | 1 | Sticky row-range lock state |

## Verification
The bench builds the block with its default parameters: three pages of 256 rows of 32 columns, and a 4-bit page field. With these values the bench can reach every entry of the page-0 lock table and both ends of the page-2 protected range. It can also reach an address on page 3, which is outside the array but still encodable, so the refused path for an invalid page is exercised for both reads and programs.

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl #(
  parameter int PAGES  = 3,
  parameter int ROWS   = 256,
  parameter int COLS   = 32,
  parameter int PAGE_W = 4,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = PAGE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_en,
  input  logic              lock_wr,
  input  logic              lock_wdata,
  input  logic              pgm_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cache_load,
  output logic              busy,
  output logic [COLS-1:0]   rd_data,
  output logic              pgm_done,
  output logic              pgm_err,
  output logic              rd_done,
  output logic              rd_err,
  output logic [PAGES-1:0]  tbit_status,
  output logic              cache_done,
  output logic              lock_q
);

  localparam int DEPTH     = PAGES * ROWS;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int LK_ROW    = 43;
  localparam int SYN_PAGE  = 2;
  localparam int SYN_LO    = 129 * COLS;
  localparam int SYN_HI    = 255 * COLS + 27;
  localparam int SYN_LKCOL = 16;
  localparam int TB_COL    = COLS - 4;
  localparam logic [COLS-1:0] ANCHOR = (COLS'(1) << 27) | (COLS'(1) << 1);

  logic [COLS-1:0] mem [DEPTH];

  logic [COL_W-1:0]  a_col;
  logic [ROW_W-1:0]  a_row;
  logic [PAGE_W-1:0] a_page;
  logic [ROW_W+COL_W-1:0] a_pos;

  assign a_col  = addr[COL_W-1:0];
  assign a_row  = addr[COL_W +: ROW_W];
  assign a_page = addr[COL_W+ROW_W +: PAGE_W];
  assign a_pos  = addr[ROW_W+COL_W-1:0];

  function automatic logic in_rng(input logic [ROW_W-1:0] r, input int lo, input int hi);
    return (int'(r) >= lo) && (int'(r) <= hi);
  endfunction

  logic take_pgm, take_rd;
  assign take_pgm = pgm_req && !busy;
  assign take_rd  = rd_req && !busy && !pgm_req;

  logic             lk_has;
  logic [ROW_W-1:0] lk_row;
  logic [COL_W-1:0] lk_col;

  always_comb begin
    lk_has = 1'b1;
    lk_row = ROW_W'(LK_ROW);
    lk_col = '0;
    if (int'(a_row) == 4) begin
      lk_row = ROW_W'(4);
      lk_col = COL_W'(31);
    end
    else if (in_rng(a_row, 8, 11))  lk_col = COL_W'(27);
    else if (in_rng(a_row, 12, 19)) lk_col = COL_W'(11);
    else if (in_rng(a_row, 20, 27)) lk_col = COL_W'(13);
    else if (in_rng(a_row, 28, 35)) lk_col = COL_W'(15);
    else if (int'(a_row) == 37)     lk_col = COL_W'(28);
    else if (in_rng(a_row, 64, 71)) lk_col = COL_W'(6);
    else if (in_rng(a_row, 72, 79)) lk_col = COL_W'(7);
    else if (in_rng(a_row, 80, 87)) lk_col = COL_W'(8);
    else lk_has = 1'b0;
  end

  logic page_ok, pg0, row_lock, range_lock, syn_lock, pgm_ok, rd_ok;
  logic [IDX_W-1:0] a_idx;

  assign page_ok    = int'(a_page) < PAGES;
  assign pg0        = a_page == '0;
  assign row_lock   = lk_has && mem[IDX_W'(lk_row)][lk_col];
  assign range_lock = lock_q && in_rng(a_row, 44, 51);
  assign syn_lock   = (int'(a_page) == SYN_PAGE) && (int'(a_pos) >= SYN_LO) &&
                      (int'(a_pos) <= SYN_HI) && mem[IDX_W'(LK_ROW)][SYN_LKCOL];
  assign pgm_ok     = page_ok && pgm_en && !(pg0 && (row_lock || range_lock)) && !syn_lock;
  assign rd_ok      = page_ok && !(pg0 && in_rng(a_row, 12, 35));
  assign a_idx      = IDX_W'(int'(a_page) * ROWS + int'(a_row));

  logic             s_valid, s_pgm, s_ok, s_row0;
  logic [IDX_W-1:0] s_idx;
  logic [COL_W-1:0] s_col;
  logic [PAGE_W-1:0] s_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_pgm   <= 1'b0;
      s_ok    <= 1'b0;
      s_row0  <= 1'b0;
      s_idx   <= '0;
      s_col   <= '0;
      s_page  <= '0;
    end else begin
      s_valid <= take_pgm || take_rd;
      if (take_pgm || take_rd) begin
        s_pgm  <= take_pgm;
        s_ok   <= take_pgm ? pgm_ok : rd_ok;
        s_row0 <= a_row == '0;
        s_idx  <= a_idx;
        s_col  <= a_col;
        s_page <= a_page;
      end
    end
  end

  assign busy = s_valid;

  logic commit_set;
  assign commit_set = s_valid && s_pgm && s_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i % ROWS == 0) ? ANCHOR : '0;
    end else if (commit_set) begin
      mem[s_idx][s_col] <= 1'b1;
    end
  end

  logic [COLS-1:0]  row0n [PAGES];
  logic [PAGES-1:0] tb_next;
  logic             tb_refresh;

  always_comb begin
    for (int p = 0; p < PAGES; p++) begin
      row0n[p] = mem[p*ROWS];
      if (commit_set && s_row0 && int'(s_page) == p) row0n[p][s_col] = 1'b1;
      tb_next[p] = &row0n[p][COLS-1:TB_COL];
    end
  end

  assign tb_refresh = cache_load || (commit_set && s_row0 && int'(s_col) >= TB_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data     <= '0;
      pgm_done    <= 1'b0;
      pgm_err     <= 1'b0;
      rd_done     <= 1'b0;
      rd_err      <= 1'b0;
      tbit_status <= '0;
      cache_done  <= 1'b0;
      lock_q      <= 1'b0;
    end else begin
      pgm_done <= s_valid && s_pgm;
      pgm_err  <= s_valid && s_pgm && !s_ok;
      rd_done  <= s_valid && !s_pgm;
      rd_err   <= s_valid && !s_pgm && !s_ok;
      if (s_valid && !s_pgm) rd_data <= s_ok ? mem[s_idx] : '0;
      if (tb_refresh) tbit_status <= tb_next;
      if (cache_load) cache_done <= 1'b1;
      if (lock_wr && lock_wdata) lock_q <= 1'b1;
    end
  end

endmodule

// File: rtl/fuse_access_ctrl_chk.sv
module fuse_access_ctrl_chk #(
  parameter int COLS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pgm_en,
  input logic            pgm_req,
  input logic            lock_wr,
  input logic            lock_wdata,
  input logic            busy,
  input logic [COLS-1:0] rd_data,
  input logic            pgm_done,
  input logic            pgm_err,
  input logic            rd_done,
  input logic            rd_err,
  input logic            cache_done,
  input logic            lock_q
);

  assert_refused_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && !busy && !pgm_en) |=> ##1 pgm_err);

  assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && lock_wdata) |=> lock_q);

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_err |-> pgm_done);

  assert_rd_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_done && rd_data == '0));

  assert_rd_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(rd_data));

  assert_cache_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cache_done |=> cache_done);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_done || rd_done) |=> !(pgm_done || rd_done));

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_done || rd_done) |-> $past(busy));

  assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pgm_done, rd_done}) <= 1);

endmodule

bind fuse_access_ctrl fuse_access_ctrl_chk #(.COLS(COLS)) chk (
  .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .pgm_req(pgm_req),
  .lock_wr(lock_wr), .lock_wdata(lock_wdata), .busy(busy), .rd_data(rd_data),
  .pgm_done(pgm_done), .pgm_err(pgm_err), .rd_done(rd_done), .rd_err(rd_err),
  .cache_done(cache_done), .lock_q(lock_q)
);

// File: tb/tb_fuse_access_ctrl.sv
`timescale 1ns/1ps
module tb_fuse_access_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pgm_en = 1'b0, lock_wr = 1'b0, lock_wdata = 1'b0;
  logic        pgm_req = 1'b0, rd_req = 1'b0, cache_load = 1'b0;
  logic [16:0] addr = '0;
  logic        busy, pgm_done, pgm_err, rd_done, rd_err, cache_done, lock_q;
  logic [31:0] rd_data;
  logic [2:0]  tbit_status;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fuse_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .lock_wr(lock_wr),
    .lock_wdata(lock_wdata), .pgm_req(pgm_req), .rd_req(rd_req), .addr(addr),
    .cache_load(cache_load), .busy(busy), .rd_data(rd_data),
    .pgm_done(pgm_done), .pgm_err(pgm_err), .rd_done(rd_done), .rd_err(rd_err),
    .tbit_status(tbit_status), .cache_done(cache_done), .lock_q(lock_q)
  );

  function automatic logic [16:0] A(input int pg, input int rw, input int cl);
    return {4'(pg), 8'(rw), 5'(cl)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pgm(input string req, input logic [16:0] a, input logic exp_err);
    @(negedge clk); pgm_req = 1'b1; addr = a;
    @(negedge clk); pgm_req = 1'b0;
    @(negedge clk);
    check(req, {30'd0, pgm_done, pgm_err}, {30'd0, 1'b1, exp_err});
  endtask

  task automatic rd(input string req, input logic [16:0] a, input logic [31:0] exp_d,
                    input logic exp_err);
    @(negedge clk); rd_req = 1'b1; addr = a;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
    check(req, {30'd0, rd_done, rd_err}, {30'd0, 1'b1, exp_err});
    check(req, rd_data, exp_d);
  endtask

  task automatic t_reset;
    check("R8 pulses/status", {busy, pgm_done, pgm_err, rd_done, rd_err, cache_done, lock_q, tbit_status},
          10'd0);
    rd("R8 anchors page0 (R1 column ignored)", A(0, 0, 9), 32'h0800_0002, 1'b0);
    rd("R8 anchors page1", A(1, 0, 0), 32'h0800_0002, 1'b0);
    rd("R8 anchors page2", A(2, 0, 31), 32'h0800_0002, 1'b0);
    rd("R8 other row clear", A(2, 200, 0), 32'h0, 1'b0);
  endtask

  task automatic t_disabled;
    pgm_en = 1'b0;
    pgm("R2 refused while disabled", A(1, 5, 3), 1'b1);
    rd("R2 array unchanged", A(1, 5, 0), 32'h0, 1'b0);
    pgm_en = 1'b1;
  endtask

  task automatic t_fields;
    pgm("R1 program p1 r5 c3", A(1, 5, 3), 1'b0);
    rd("R1 field positions", A(1, 5, 17), 32'h0000_0008, 1'b0);
    pgm("R6 reprogram set bit no error", A(1, 5, 3), 1'b0);
    pgm("R1 program p1 r5 c31", A(1, 5, 31), 1'b0);
    rd("R6 bits accumulate", A(1, 5, 0), 32'h8000_0008, 1'b0);
  endtask

  task automatic t_read_block;
    pgm("R7 key row programmable", A(0, 12, 0), 1'b0);
    rd("R7 row 12 blocked", A(0, 12, 0), 32'h0, 1'b1);
    rd("R7 row 35 blocked", A(0, 35, 0), 32'h0, 1'b1);
    rd("R7 row 36 open", A(0, 36, 0), 32'h0, 1'b0);
    rd("R7 page1 row 12 open", A(1, 12, 0), 32'h0, 1'b0);
    rd("R12 invalid page read", A(3, 0, 0), 32'h0, 1'b1);
    pgm("R6 invalid page program", A(3, 1, 1), 1'b1);
  endtask

  task automatic t_row_lock;
    pgm("R4 row 20 before lock", A(0, 20, 2), 1'b0);
    pgm("R4 set lock fuse r43 c13", A(0, 43, 13), 1'b0);
    pgm("R4 row 20 refused", A(0, 20, 3), 1'b1);
    pgm("R4 row 27 refused", A(0, 27, 0), 1'b1);
    pgm("R4 row 28 still open", A(0, 28, 0), 1'b0);
    rd("R4 lock row content", A(0, 43, 0), 32'h0000_2000, 1'b0);
    pgm("R4 row 4 open", A(0, 4, 0), 1'b0);
    pgm("R4 row 4 self lock bit", A(0, 4, 31), 1'b0);
    pgm("R4 row 4 refused", A(0, 4, 1), 1'b1);
    rd("R4 row 4 content", A(0, 4, 0), 32'h8000_0001, 1'b0);
    pgm("R4 row 37 open", A(0, 37, 0), 1'b0);
    pgm("R4 set r43 c28", A(0, 43, 28), 1'b0);
    pgm("R4 row 37 refused", A(0, 37, 1), 1'b1);
    pgm("R4 row 36 unlisted", A(0, 36, 1), 1'b0);
  endtask

  task automatic t_sticky;
    pgm("R3 row 44 before lock", A(0, 44, 0), 1'b0);
    @(negedge clk); lock_wr = 1'b1; lock_wdata = 1'b1;
    @(negedge clk); lock_wr = 1'b0; lock_wdata = 1'b0;
    check("R3 lock set", {31'd0, lock_q}, 32'd1);
    pgm("R3 row 51 refused", A(0, 51, 31), 1'b1);
    pgm("R3 row 44 refused", A(0, 44, 1), 1'b1);
    pgm("R3 row 52 open", A(0, 52, 0), 1'b0);
    pgm("R3 page1 row 44 open", A(1, 44, 0), 1'b0);
    @(negedge clk); lock_wr = 1'b1; lock_wdata = 1'b0;
    @(negedge clk); lock_wr = 1'b0;
    check("R3 lock sticky", {31'd0, lock_q}, 32'd1);
  endtask

  task automatic t_page2;
    pgm("R5 p2 r129 c0 before lock", A(2, 129, 0), 1'b0);
    pgm("R5 set r43 c16", A(0, 43, 16), 1'b0);
    pgm("R5 p2 r129 c1 refused", A(2, 129, 1), 1'b1);
    pgm("R5 p2 r255 c27 refused", A(2, 255, 27), 1'b1);
    pgm("R5 p2 r255 c28 open", A(2, 255, 28), 1'b0);
    pgm("R5 p2 r128 c31 open", A(2, 128, 31), 1'b0);
    pgm("R5 p1 r200 open", A(1, 200, 0), 1'b0);
    rd("R5 p2 r129 content", A(2, 129, 0), 32'h0000_0001, 1'b0);
  endtask

  task automatic t_tbits;
    pgm("R9 p1 c28", A(1, 0, 28), 1'b0);
    pgm("R9 p1 c29", A(1, 0, 29), 1'b0);
    pgm("R9 p1 c30", A(1, 0, 30), 1'b0);
    check("R9 partial no flag", {29'd0, tbit_status}, 32'd0);
    pgm("R9 p1 c31", A(1, 0, 31), 1'b0);
    check("R9 page1 flag", {29'd0, tbit_status}, 32'b010);
    check("R10 cache_done clear", {31'd0, cache_done}, 32'd0);
    @(negedge clk); cache_load = 1'b1;
    @(negedge clk); cache_load = 1'b0;
    check("R10 cache_done set", {31'd0, cache_done}, 32'd1);
    check("R9 refresh keeps flag", {29'd0, tbit_status}, 32'b010);
  endtask

  task automatic t_timing;
    @(negedge clk); pgm_req = 1'b1; addr = A(1, 9, 4);
    @(negedge clk);
    check("R11 busy after accept", {31'd0, busy}, 32'd1);
    addr = A(1, 9, 5);
    @(negedge clk); pgm_req = 1'b0;
    check("R11 done one cycle later", {31'd0, pgm_done}, 32'd1);
    @(negedge clk);
    rd("R11 busy request ignored", A(1, 9, 0), 32'h0000_0010, 1'b0);
    @(negedge clk); pgm_req = 1'b1; rd_req = 1'b1; addr = A(1, 10, 2);
    @(negedge clk); pgm_req = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    check("R11 program wins", {30'd0, pgm_done, rd_done}, 32'b10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fields();
    t_read_block();
    t_row_lock();
    t_sticky();
    t_page2();
    t_tbits();
    t_timing();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule